// File: doc/BRIEF.md
# Bus-Stall Timeout Timer

This block watches a serial bus master for a clock line that a target holds low for too long. The transfer engine raises `stall_i` while it is waiting for the clock line to be released. While the timer is enabled and the stall persists, a prescaler divides the input clock by a power of two and a 15-bit counter counts the divided ticks. When the counter passes a programmed limit, the block emits a single-cycle timeout event. The master status logic latches that event as its timeout flag, which it treats as an error alongside arbitration loss, NAK and invalid-parameter conditions.

Two configuration registers are held inside the block. The control word carries an enable flag and the limit. The divider word carries the base-2 exponent of the prescaler. Both registers are visible on read-back outputs. Any break in the stall, or clearing the enable, restarts the measurement from a clean prescaler phase.

Top module: `stall_tmr`

## Requirements
- R1: A write of the control word loads the enable from bit 15 and the limit from bits 14:0. `ctrl_o` returns that word from the cycle after the write.
- R2: A write of the divider word loads a 4-bit exponent. Values above 14 are stored as 14. `div_o` returns the stored exponent.
- R3: With exponent N and limit L, `tmo_o` is high in the cycle after the (L+1)*2^N-th consecutive rising edge at which both `stall_i` and the enable are sampled high. This holds for N from 0 to 14.
- R4: A limit of 0 with the timer enabled expires after the first prescaled tick, which is 2^N stalled cycles.
- R5: `tmo_o` is high for exactly one cycle per expiry.
- R6: While the stall continues after an expiry, no further event occurs. Once the stall drops and rises again, a new event follows after a full new interval.
- R7: Dropping `stall_i` for a single cycle clears both the count and the prescaler phase, so the next interval is measured from zero.
- R8: With the enable clear, no event is produced however long the stall lasts. Clearing the enable mid-count discards the progress made so far.
- R9: After reset the control word and the exponent are 0 and `tmo_o` is low.
- R10: `tmo_o` is high only in a cycle whose preceding rising edge sampled `stall_i` high with the enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word: bit 15 enable, bits 14:0 limit |
| div_we | input | 1 | Write strobe for the divider word |
| div_wdata | input | 4 | Prescaler exponent, saturated at 14 |
| stall_i | input | 1 | Transfer engine is waiting on the clock line |
| ctrl_o | output | 16 | Control word read-back |
| div_o | output | 4 | Stored exponent read-back |
| tmo_o | output | 1 | One-cycle timeout event |

## Verification
The assertions check four properties on every cycle:
- the event lasts a single cycle;
- no event follows an edge where the stall or the enable was low;
- the stored exponent stays within range;
- no second event occurs within one unbroken stall.

Only the bench scenarios can show the exact expiry cycle for each exponent and limit pair, including the largest exponent. The same applies to the restart after a brief stall break, the discarded progress when the enable is toggled, and the saturation of divider writes.

// File: rtl/stall_tmr_pkg.sv
package stall_tmr_pkg;
    localparam int unsigned DEF_CNT_W   = 15;
    localparam int unsigned DEF_EXP_W   = 4;
    localparam int unsigned DEF_EXP_MAX = 14;
endpackage

// File: rtl/stall_tmr_cfg.sv
module stall_tmr_cfg #(
    parameter int unsigned CNT_W   = 15,
    parameter int unsigned EXP_W   = 4,
    parameter int unsigned EXP_MAX = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [CNT_W:0]   ctrl_wdata,
    input  logic             div_we,
    input  logic [EXP_W-1:0] div_wdata,
    output logic             en,
    output logic [CNT_W-1:0] lim,
    output logic [EXP_W-1:0] expn
);
    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] lim;
        logic [EXP_W-1:0] expn;
    } cfg_t;

    localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(EXP_MAX);

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.en  = ctrl_wdata[CNT_W];
            st_d.lim = ctrl_wdata[CNT_W-1:0];
        end
        if (div_we) begin
            st_d.expn = (div_wdata > EXP_TOP) ? EXP_TOP : div_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en   = st_q.en;
    assign lim  = st_q.lim;
    assign expn = st_q.expn;
endmodule

// File: rtl/stall_tmr_presc.sv
module stall_tmr_presc #(
    parameter int unsigned PRE_W = 14,
    parameter int unsigned EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] expn,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } presc_t;

    presc_t st_d, st_q;
    logic [PRE_W-1:0] wrap_val;

    always_comb begin
        wrap_val = ~({PRE_W{1'b1}} << expn);
        tick     = run && (st_q.pre == wrap_val);
        st_d     = st_q;
        if (!run)      st_d.pre = '0;
        else if (tick) st_d.pre = '0;
        else           st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/stall_tmr_cnt.sv
module stall_tmr_cnt #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] lim,
    output logic             tmo
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fired;
        logic             pulse;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!run) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else if (tick && !st_q.fired) begin
            if (st_q.cnt == lim) begin
                st_d.fired = 1'b1;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmo = st_q.pulse;
endmodule

// File: rtl/stall_tmr.sv
module stall_tmr
    import stall_tmr_pkg::*;
#(
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned EXP_W   = DEF_EXP_W,
    parameter int unsigned EXP_MAX = DEF_EXP_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [CNT_W:0]   ctrl_wdata,
    input  logic             div_we,
    input  logic [EXP_W-1:0] div_wdata,
    input  logic             stall_i,
    output logic [CNT_W:0]   ctrl_o,
    output logic [EXP_W-1:0] div_o,
    output logic             tmo_o
);
    localparam int unsigned PRE_W = (EXP_MAX > 0) ? EXP_MAX : 1;

    logic             en;
    logic [CNT_W-1:0] lim;
    logic [EXP_W-1:0] expn;
    logic             active;
    logic             tick;

    stall_tmr_cfg #(.CNT_W(CNT_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .div_we(div_we), .div_wdata(div_wdata),
        .en(en), .lim(lim), .expn(expn)
    );

    assign active = en && stall_i;

    stall_tmr_presc #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(active), .expn(expn), .tick(tick)
    );

    stall_tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(active), .tick(tick),
        .lim(lim), .tmo(tmo_o)
    );

    assign ctrl_o = {en, lim};
    assign div_o  = expn;
endmodule

// File: rtl/stall_tmr_chk.sv
module stall_tmr_chk #(
    parameter int unsigned CNT_W   = 15,
    parameter int unsigned EXP_W   = 4,
    parameter int unsigned EXP_MAX = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall_i,
    input logic [CNT_W:0]   ctrl_o,
    input logic [EXP_W-1:0] div_o,
    input logic             tmo_o
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           armed_q <= 1'b0;
        else if (!stall_i || !ctrl_o[CNT_W])  armed_q <= 1'b0;
        else if (tmo_o)                       armed_q <= 1'b1;
    end

    p_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |=> !tmo_o);

    p_needs_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall_i && ctrl_o[CNT_W]) |=> !tmo_o);

    p_exp_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_o <= EXP_W'(EXP_MAX));

    p_no_refire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |-> !armed_q);
endmodule

bind stall_tmr stall_tmr_chk #(.CNT_W(CNT_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
    .ctrl_o(ctrl_o), .div_o(div_o), .tmo_o(tmo_o)
);

// File: tb/stall_tmr_tb.sv
`timescale 1ns/1ps
module stall_tmr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        div_we = 1'b0;
    logic [3:0]  div_wdata = '0;
    logic        stall_i = 1'b0;
    logic [15:0] ctrl_o;
    logic [3:0]  div_o;
    logic        tmo_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stall_tmr u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .div_we(div_we), .div_wdata(div_wdata), .stall_i(stall_i),
        .ctrl_o(ctrl_o), .div_o(div_o), .tmo_o(tmo_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_div(input logic [3:0] v);
        @(negedge clk); div_we = 1'b1; div_wdata = v;
        @(negedge clk); div_we = 1'b0;
    endtask

    task automatic set_stall(input logic v);
        @(negedge clk); stall_i = v;
    endtask

    // Edge index (from stall rise) of first pulse, 0 if none within lim edges.
    task automatic first_pulse(input int lim, output int at, output int width);
        at = 0; width = 0;
        for (int k = 1; k <= lim; k++) begin
            @(posedge clk); #1;
            if (tmo_o) begin
                if (at == 0) at = k;
                width++;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int at, w, tgt;
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state
        chk(ctrl_o == 16'h0, "R9 ctrl after reset", ctrl_o, 0);
        chk(div_o == 4'h0, "R9 div after reset", div_o, 0);
        chk(tmo_o == 1'b0, "R9 tmo after reset", tmo_o, 0);
        rst_n = 1'b1;

        // R1: control readback
        wr_ctrl(16'h8005); #1;
        chk(ctrl_o == 16'h8005, "R1 ctrl readback", ctrl_o, 16'h8005);
        wr_ctrl(16'h7abc); #1;
        chk(ctrl_o == 16'h7abc, "R1 ctrl readback no enable", ctrl_o, 16'h7abc);

        // R2: exponent saturation
        wr_div(4'd15); #1;
        chk(div_o == 4'd14, "R2 div clamp 15", div_o, 14);
        wr_div(4'd9); #1;
        chk(div_o == 4'd9, "R2 div write 9", div_o, 9);

        // R3 / R4 / R5 / R6: sweep exponent and limit
        for (int e = 0; e <= 4; e++) begin
            for (int li = 0; li < 4; li++) begin
                int lv;
                lv = (li == 3) ? 5 : li;
                tgt = (lv + 1) << e;
                wr_div(4'(e));
                wr_ctrl(16'h8000 | 16'(lv));
                set_stall(1'b1);
                for (int k = 1; k <= tgt + 2; k++) begin
                    @(posedge clk); #1;
                    chk(tmo_o == (k == tgt), (lv == 0) ? "R4 expiry cycle" : "R3 expiry cycle",
                        tmo_o, (k == tgt));
                end
                first_pulse(2 * tgt + 4, at, w);
                chk(w == 0, "R6 no refire while stalled", w, 0);
                set_stall(1'b0);
                set_stall(1'b1);
                first_pulse(tgt + 3, at, w);
                chk(at == tgt, "R6 refire after new stall", at, tgt);
                chk(w == 1, "R5 single cycle pulse", w, 1);
                set_stall(1'b0);
            end
        end

        // R3 at maximum exponent
        wr_div(4'd14);
        wr_ctrl(16'h8000);
        set_stall(1'b1);
        first_pulse(16384 + 3, at, w);
        chk(at == 16384, "R3 max exponent expiry", at, 16384);
        chk(w == 1, "R5 max exponent width", w, 1);
        set_stall(1'b0);

        // R7: brief stall break restarts count and prescaler phase
        wr_div(4'd2);
        wr_ctrl(16'h8002);
        set_stall(1'b1);
        first_pulse(7, at, w);
        chk(w == 0, "R7 no pulse before break", w, 0);
        set_stall(1'b0);
        set_stall(1'b1);
        first_pulse(15, at, w);
        chk(at == 12, "R7 full interval after break", at, 12);
        set_stall(1'b0);

        // R8: disabled timer never fires
        wr_div(4'd0);
        wr_ctrl(16'h0000);
        set_stall(1'b1);
        first_pulse(60, at, w);
        chk(w == 0, "R8 disabled no pulse", w, 0);
        set_stall(1'b0);

        // R8: clearing enable mid-count discards progress
        wr_div(4'd1);
        wr_ctrl(16'h8003);
        set_stall(1'b1);
        first_pulse(5, at, w);
        chk(w == 0, "R8 partial count", w, 0);
        wr_ctrl(16'h0003);
        wr_ctrl(16'h8003);
        first_pulse(11, at, w);
        chk(at == 8, "R8 restart after re-enable", at, 8);
        set_stall(1'b0);

        // R10: stall low never pulses even when enabled
        wr_div(4'd0);
        wr_ctrl(16'h8000);
        first_pulse(20, at, w);
        chk(w == 0, "R10 no stall no pulse", w, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule